// File: doc/BRIEF.md
# Flash Line Prefetch Buffer Controller

This block sits between a 64-bit system read port and a 128-bit non-volatile array read path. It keeps four 128-bit line buffers. A read whose line is already in a buffer is answered in the same cycle it is presented. A read that misses starts one array fetch. The requester then waits for a programmable number of wait states, chosen from the clock-frequency class. The returned line fills the least-recently-used buffer, and the requested 64-bit half is delivered in the same cycle.

The system side presents a double-word address, which is the byte address with its three low bits dropped. It holds `req_valid`, `req_dw` and `ws_sel` steady until `rsp_ready` is seen high. An invalidate input discards every buffered line. The array is modelled inside the block as a read-only synchronous memory with one cycle of latency. Its contents are a fixed arithmetic pattern, so that any line can be predicted.

Top module: `lbuf_flash_rd`

## Requirements
- R1: A request whose line is held in a valid buffer gets `rsp_ready` high in the same cycle it is presented, with zero wait states and the correct data.
- R2: A request that misses holds `rsp_ready` low for exactly N cycles and then raises it. N is `ws_sel` when `ws_sel` is 1, 2 or 3, and a `ws_sel` of 0 gives N = 3.
- R3: Array line L is made of four 32-bit words, with word k equal to `((L<<2)|k) ^ 32'h5A5A0000` and word 0 in the least significant position. `req_dw[0]` (byte address bit 3) selects the half: 0 returns words {1,0} and 1 returns words {3,2}. The line number L is `req_dw[AW-4:1]`.
- R4: Four distinct lines can be held at once, and after all four are fetched each of them hits.
- R5: A miss replaces the least-recently-used buffer, and every hit or fill makes that buffer the most recently used.
- R6: Asserting `inval` for one cycle clears all buffers, so the next access to any previously held line misses.
- R7: When `inval` is high in the same cycle as an idle-state request, no lookup is made. `rsp_ready` stays low and no array fetch starts.
- R8: At most one array fetch is outstanding at a time. The fill happens in the same cycle as the response.
- R9: After reset all buffers are empty, `rsp_ready` is low while no request is made, and the first access misses.
- R10: If `inval` is high during a fetch, the response is still delivered with correct data but the line is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_sel | input | WS_W | Wait-state setting for misses (0 selects the maximum) |
| inval | input | 1 | Invalidate all line buffers |
| req_valid | input | 1 | Read request present |
| req_dw | input | AW-3 | Double-word address of the read (byte address bits AW-1..3) |
| rsp_ready | output | 1 | Read data valid, request complete |
| rsp_data | output | 64 | Read data |

## Verification
A stale or duplicated tag, or a wrong replacement order, shows up at the ports only as a change in timing. A line that should hit costs N wait states, or a line that should miss answers at once. This appears on the first access to the affected line after the fault, which may be several requests later. The bench therefore tracks buffer contents and recency with its own model and checks the wait count of every access. A wrong half select or fill path shows as wrong data in the response cycle itself. Invalidate faults show on the next access to any earlier line.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} fsm_t;

   localparam int SYS_W  = 64;
   localparam int LINE_W = 2 * SYS_W;
   localparam int WORD_W = 32;
   localparam int WORDS  = LINE_W / WORD_W;
   localparam logic [WORD_W-1:0] ARR_SALT = 32'h5A5A_0000;
endpackage

// File: rtl/lbuf_array.sv
module lbuf_array #(
   parameter int TAG_W = 12
) (
   input  logic                        clk,
   input  logic                        rd,
   input  logic [TAG_W-1:0]            line,
   output logic [lbuf_pkg::LINE_W-1:0] q
);
   import lbuf_pkg::*;

   logic [LINE_W-1:0] content;

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      assign content[k*WORD_W +: WORD_W] =
         ((WORD_W'(line) << 2) | WORD_W'(k)) ^ ARR_SALT;
   end

   always_ff @(posedge clk) begin
      if (rd) q <= content;
   end
endmodule

// File: rtl/lbuf_ways.sv
module lbuf_ways #(
   parameter int NWAY  = 4,
   parameter int TAG_W = 12,
   localparam int IDX_W = $clog2(NWAY)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        fill_en,
   input  logic [IDX_W-1:0]            fill_way,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic [lbuf_pkg::LINE_W-1:0] fill_line,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic [NWAY-1:0]             hit_vec,
   output logic [lbuf_pkg::LINE_W-1:0] hit_line,
   output logic [NWAY-1:0]             valid_vec
);
   import lbuf_pkg::*;

   logic [LINE_W-1:0] masked [NWAY];

   for (genvar w = 0; w < NWAY; w++) begin : g_way
      logic              valid_q;
      logic [TAG_W-1:0]  tag_q;
      logic [LINE_W-1:0] line_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            line_q  <= '0;
         end else if (clr) begin
            valid_q <= 1'b0;
         end else if (fill_en && fill_way == IDX_W'(w)) begin
            valid_q <= 1'b1;
            tag_q   <= fill_tag;
            line_q  <= fill_line;
         end
      end

      assign valid_vec[w] = valid_q;
      assign hit_vec[w]   = valid_q && (tag_q == lk_tag);
      assign masked[w]    = hit_vec[w] ? line_q : '0;
   end

   always_comb begin
      hit_line = '0;
      for (int w = 0; w < NWAY; w++) hit_line = hit_line | masked[w];
   end
endmodule

// File: rtl/lbuf_lru.sv
module lbuf_lru #(
   parameter int NWAY = 4,
   localparam int IDX_W = $clog2(NWAY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_way,
   output logic [IDX_W-1:0] victim
);
   logic [IDX_W-1:0] age [NWAY];
   logic [IDX_W-1:0] touched_age;

   assign touched_age = age[touch_way];

   for (genvar w = 0; w < NWAY; w++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age[w] <= IDX_W'(w);
         end else if (touch_en) begin
            if (touch_way == IDX_W'(w))      age[w] <= '0;
            else if (age[w] < touched_age)   age[w] <= age[w] + 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int w = 0; w < NWAY; w++) begin
         if (age[w] == IDX_W'(NWAY - 1)) victim = IDX_W'(w);
      end
   end
endmodule

// File: rtl/lbuf_flash_rd.sv
module lbuf_flash_rd #(
   parameter int AW   = 16,
   parameter int NWAY = 4,
   parameter int WS_W = 2,
   localparam int DWA_W = AW - 3,
   localparam int TAG_W = AW - 4,
   localparam int IDX_W = $clog2(NWAY)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [WS_W-1:0]            ws_sel,
   input  logic                       inval,
   input  logic                       req_valid,
   input  logic [DWA_W-1:0]           req_dw,
   output logic                       rsp_ready,
   output logic [lbuf_pkg::SYS_W-1:0] rsp_data
);
   import lbuf_pkg::*;

   localparam logic [WS_W-1:0] WS_MAX = {WS_W{1'b1}};

   if (NWAY < 2 || (NWAY & (NWAY - 1)) != 0) begin : g_bad_nway
      $error("NWAY must be a power of two, at least 2");
   end
   if (AW < 6 || AW > 30) begin : g_bad_aw
      $error("AW must lie between 6 and 30");
   end
   if (WS_W < 1 || WS_W > 4) begin : g_bad_ws
      $error("WS_W must lie between 1 and 4");
   end

   fsm_t              state;
   logic [WS_W-1:0]   cnt;
   logic [TAG_W-1:0]  miss_tag;
   logic              miss_half;
   logic [WS_W-1:0]   ws_eff;

   logic              in_idle, lookup, hit, fill_fire, fill_en, arr_rd, touch_en;
   logic [NWAY-1:0]   hit_vec, valid_vec;
   logic [IDX_W-1:0]  hit_idx, victim, touch_way;
   logic [LINE_W-1:0] hit_line, arr_q, rsp_line;
   logic              rsp_half;
   logic [TAG_W-1:0]  req_tag;

   assign req_tag   = req_dw[DWA_W-1:1];
   assign ws_eff    = (ws_sel == '0) ? WS_MAX : ws_sel;
   assign in_idle   = (state == ST_IDLE);
   assign lookup    = in_idle && req_valid && !inval;
   assign hit       = |hit_vec;
   assign arr_rd    = lookup && !hit;
   assign fill_fire = (state == ST_WAIT) && (cnt == '0);
   assign fill_en   = fill_fire && !inval;
   assign touch_en  = (lookup && hit) || fill_en;
   assign touch_way = fill_en ? victim : hit_idx;

   always_comb begin
      hit_idx = '0;
      for (int w = 0; w < NWAY; w++) begin
         if (hit_vec[w]) hit_idx = IDX_W'(w);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         miss_tag  <= '0;
         miss_half <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (arr_rd) begin
               state     <= ST_WAIT;
               cnt       <= ws_eff - 1'b1;
               miss_tag  <= req_tag;
               miss_half <= req_dw[0];
            end
            ST_WAIT: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   lbuf_array #(.TAG_W(TAG_W)) u_array (
      .clk  (clk),
      .rd   (arr_rd),
      .line (req_tag),
      .q    (arr_q)
   );

   lbuf_ways #(.NWAY(NWAY), .TAG_W(TAG_W)) u_ways (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (inval),
      .fill_en   (fill_en),
      .fill_way  (victim),
      .fill_tag  (miss_tag),
      .fill_line (arr_q),
      .lk_tag    (req_tag),
      .hit_vec   (hit_vec),
      .hit_line  (hit_line),
      .valid_vec (valid_vec)
   );

   lbuf_lru #(.NWAY(NWAY)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .victim    (victim)
   );

   assign rsp_ready = (lookup && hit) || fill_fire;
   assign rsp_line  = fill_fire ? arr_q : hit_line;
   assign rsp_half  = fill_fire ? miss_half : req_dw[0];
   assign rsp_data  = rsp_half ? rsp_line[LINE_W-1:SYS_W] : rsp_line[SYS_W-1:0];
endmodule

// File: rtl/lbuf_flash_rd_chk.sv
module lbuf_flash_rd_chk #(
   parameter int NWAY = 4,
   parameter int WS_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [WS_W-1:0] ws_sel,
   input logic            inval,
   input logic            req_valid,
   input logic            rsp_ready,
   input logic            arr_rd,
   input logic            in_idle,
   input logic [NWAY-1:0] hit_vec,
   input logic [NWAY-1:0] valid_vec
);
   // R1: a line is held by at most one buffer
   p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R2: wait-state count after a fetch starts
   p_ws_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd && ws_sel == WS_W'(1)) |=> rsp_ready);
   p_ws_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd && ws_sel == WS_W'(2)) |=> !rsp_ready ##1 rsp_ready);
   p_ws_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_rd && ws_sel == '0 && WS_W == 2) |=> !rsp_ready ##1 !rsp_ready ##1 rsp_ready);

   // R6: invalidate leaves no valid buffer
   p_inval_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> (valid_vec == '0));

   // R7: invalidate blocks an idle lookup
   p_inval_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inval && in_idle) |-> (!rsp_ready && !arr_rd));

   // R8: one fetch outstanding, responses only to requests
   p_one_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      arr_rd |=> !arr_rd);
   p_ready_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> req_valid);
endmodule

bind lbuf_flash_rd lbuf_flash_rd_chk #(.NWAY(NWAY), .WS_W(WS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ws_sel    (ws_sel),
   .inval     (inval),
   .req_valid (req_valid),
   .rsp_ready (rsp_ready),
   .arr_rd    (arr_rd),
   .in_idle   (in_idle),
   .hit_vec   (hit_vec),
   .valid_vec (valid_vec)
);

// File: tb/lbuf_flash_rd_test.sv
`timescale 1ns/1ps
module lbuf_flash_rd_test;
   localparam int AW = 16;
   localparam int NW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ws_sel = 2'd0;
   logic        inval = 1'b0;
   logic        req_valid = 1'b0;
   logic [AW-4:0] req_dw = '0;
   logic        rsp_ready;
   logic [63:0] rsp_data;

   int checks = 0;
   int fails  = 0;
   int stamp_ctr = 0;

   bit m_valid [NW];
   int m_tag   [NW];
   int m_stamp [NW];

   always #2 clk = ~clk;

   lbuf_flash_rd #(.AW(AW), .NWAY(NW), .WS_W(2)) uut (
      .clk, .rst_n, .ws_sel, .inval, .req_valid, .req_dw, .rsp_ready, .rsp_data
   );

   function automatic logic [31:0] word_of(int line, int k);
      return ((32'(line) << 2) | 32'(k)) ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [63:0] exp_data(int line, int half);
      return {word_of(line, 2*half+1), word_of(line, 2*half)};
   endfunction

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic model_clear();
      for (int w = 0; w < NW; w++) m_valid[w] = 1'b0;
   endtask

   // one read; expected wait count and data come from the recency model
   task automatic access(int line, int half, int ws, bit inval_mid, string req);
      int hw, waits, exp_w, vic;
      hw = -1;
      for (int w = 0; w < NW; w++) if (m_valid[w] && m_tag[w] == line) hw = w;
      exp_w = (hw >= 0) ? 0 : ((ws == 0) ? 3 : ws);
      @(negedge clk);
      req_valid = 1'b1;
      req_dw    = {12'(line), 1'(half)};
      ws_sel    = 2'(ws);
      #1;
      waits = 0;
      while (!rsp_ready && waits < 10) begin
         @(negedge clk);
         if (inval_mid) inval = 1'b1;
         #1;
         waits++;
      end
      check(waits == exp_w, req, "wait states", waits, exp_w);
      check(rsp_data == exp_data(line, half), "R3", "data", rsp_data, exp_data(line, half));
      @(negedge clk);
      req_valid = 1'b0;
      inval     = 1'b0;
      if (hw >= 0) begin
         m_stamp[hw] = ++stamp_ctr;
      end else if (inval_mid) begin
         model_clear();
      end else begin
         vic = 0;
         for (int w = 1; w < NW; w++) if (m_stamp[w] < m_stamp[vic]) vic = w;
         m_valid[vic] = 1'b1;
         m_tag[vic]   = line;
         m_stamp[vic] = ++stamp_ctr;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int w = 0; w < NW; w++) begin
         m_valid[w] = 1'b0;
         m_tag[w]   = -1;
         m_stamp[w] = -w;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(rsp_ready == 1'b0, "R9", "ready idle after reset", rsp_ready, 0);
      access(7, 0, 1, 1'b0, "R9");
      access(7, 1, 1, 1'b0, "R1");

      // R4: four lines held together
      for (int l = 10; l < 14; l++) access(l, l & 1, 2, 1'b0, "R4");
      for (int l = 10; l < 14; l++) access(l, 0, 2, 1'b0, "R4");
      for (int l = 10; l < 14; l++) access(l, 1, 2, 1'b0, "R1");

      // R5: recency decides the victim
      access(10, 0, 3, 1'b0, "R5");
      access(20, 1, 3, 1'b0, "R5");
      access(11, 0, 3, 1'b0, "R5");
      access(10, 1, 3, 1'b0, "R5");

      // R6: invalidate then previously held lines miss
      @(negedge clk); inval = 1'b1;
      @(negedge clk); inval = 1'b0;
      model_clear();
      access(10, 0, 2, 1'b0, "R6");
      access(20, 1, 0, 1'b0, "R6");

      // R7: invalidate beats a lookup in the same cycle
      @(negedge clk);
      req_valid = 1'b1; req_dw = {12'd20, 1'b0}; inval = 1'b1;
      #1;
      check(rsp_ready == 1'b0, "R7", "ready under invalidate", rsp_ready, 0);
      @(negedge clk);
      req_valid = 1'b0; inval = 1'b0;
      model_clear();
      access(20, 0, 1, 1'b0, "R7");

      // R10: invalidate during a fetch
      access(33, 1, 3, 1'b1, "R10");
      access(33, 1, 3, 1'b0, "R10");
      access(20, 0, 2, 1'b0, "R10");

      // sweep: every wait setting, six lines over four buffers
      for (int ws = 0; ws < 4; ws++) begin
         for (int i = 0; i < 120; i++) begin
            access(40 + ($urandom % 6), $urandom % 2, ws, 1'b0, "R2 R5 R8");
         end
      end
      // near the top of the line range
      access(4095, 1, 2, 1'b0, "R3");
      access(4095, 0, 2, 1'b0, "R1");
      summary();
   end
endmodule